// File: doc/BRIEF.md
# Program Counter and Call/Interrupt Sequencer

This block keeps the 12-bit fetch address of a 4-bit microcontroller core. The address has two parts: a 4-bit page in the upper bits and an 8-bit step in the lower bits. The decoder drives one instruction strobe per cycle. The block answers each strobe in one of two ways. A sequential instruction moves the step forward. A page preset arms a page for the next jump or call. A jump loads the address directly. A call or a return starts a short sequence that moves a return address through a 4-bit-wide stack memory, one nibble per cycle.

The block also decides when an interrupt request may be taken. An interrupt may be taken only when interrupts are enabled, no sequence is running and no instruction strobe is present. It is also refused between a page preset and the completion of the instruction that follows it, so that a two-part far jump is never split. An interrupt entry is a fixed-length sequence. It saves the current address on the stack, clears the enable flag and continues at the vector. While any sequence runs, `busy_o` is high and every instruction strobe is ignored.

Top module: `pc_sequencer`

## Requirements
- R1: Two cycles after reset is released, `pc_o` is 0x000, `busy_o` is 0, `ie_o` is 0, neither stack request is raised and the stack pointer holds its reset value (default 0x00).
- R2: An accepted `fetch_i` adds one to the step field `pc_o[7:0]`, wrapping from 0xFF to 0x00, and leaves the page field `pc_o[11:8]` unchanged.
- R3: An accepted `jump_i` loads `pc_o` with {page, `imm_i[7:0]`} in the next cycle. The page is the armed page if one is armed, and otherwise the current page.
- R4: An accepted `pset_i` arms the page `imm_i[3:0]` and advances the step like a fetch. Any following fetch, jump, call or return disarms it, so it is used by at most the next instruction.
- R5: An accepted `call_i` raises `busy_o` for exactly 3 cycles and writes three nibbles at stack addresses SP-1, SP-2 and SP-3, in that order: the return page, the upper step nibble and the lower step nibble. The pointer ends 3 lower, and `pc_o` is then the call target, {page, `imm_i`}.
- R6: The return address that a call saves is the full 12-bit address plus one, so a carry out of the step goes into the page: a call at 0x3FF saves 4,0,0, and a call at 0xFFF saves 0,0,0.
- R7: An accepted `ret_i` raises `busy_o` for exactly 3 cycles and reads stack addresses SP, SP+1 and SP+2 as the lower step nibble, the upper step nibble and the page. The pointer ends 3 higher, and `pc_o` becomes the address that was read.
- R8: An interrupt is taken only when all of these hold: `irq_req_i` is high, `ie_o` is 1, `busy_o` is 0, no instruction strobe is present and no preset hold is active. Entry keeps `busy_o` high for exactly 12 cycles, clears `ie_o`, saves the current unincremented address in call order, and then loads `pc_o` with `irq_vec_i`.
- R9: After an accepted `pset_i`, no interrupt is taken until the next fetch, jump, call or return strobe has been accepted.
- R10: While `busy_o` is high, every instruction strobe is ignored, and `pc_o` stays unchanged until the sequence ends.
- R11: `ei_i` sets `ie_o` and `di_i` clears it. Both take effect in the next cycle, and `di_i` wins if both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_i | input | 1 | Sequential instruction completed: advance the step |
| pset_i | input | 1 | Page preset: arm page `imm_i[3:0]` and advance the step |
| jump_i | input | 1 | Jump to {page, `imm_i`} |
| call_i | input | 1 | Call {page, `imm_i`} and save the return address |
| ret_i | input | 1 | Return to the address popped from the stack |
| ei_i | input | 1 | Set the interrupt enable flag |
| di_i | input | 1 | Clear the interrupt enable flag |
| imm_i | input | 8 | Immediate operand (step target or preset page) |
| irq_req_i | input | 1 | Pending interrupt request |
| irq_vec_i | input | 12 | Interrupt vector address {page, step} |
| stk_rdata_i | input | 4 | Stack read data, combinational from `stk_addr_o` |
| pc_o | output | 12 | Fetch address {page, step} |
| stk_addr_o | output | 8 | Stack nibble address |
| stk_wdata_o | output | 4 | Stack write data |
| stk_we_o | output | 1 | Stack write request |
| stk_re_o | output | 1 | Stack read request |
| busy_o | output | 1 | Sequence running; instruction strobes are ignored |
| ie_o | output | 1 | Interrupt enable flag |

## Verification
The bench mixes seeded random sequences of fetches, presets, jumps, calls and returns. Comparing them with a reference model separates armed-page from current-page selection and shows whether the preset is consumed by the next instruction or kept. Directed calls at 0x3FF and 0xFFF show whether the carry reaches the page, which an increment of the low nibble alone would miss. Return addresses are checked against a bench-side stack, which catches any mistake in nibble order. The interrupt cases hold the request high while enable is off, while a preset hold is active, and then through the releasing fetch. They show that the entry happens only in the cycle right after that fetch, lasts 12 cycles and saves the unincremented address. A jump strobe driven during a call shows that strobes are ignored while busy.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PUSH = 2'd1,
    SQ_POP  = 2'd2,
    SQ_IRQ  = 2'd3
  } sq_state_e;

endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
#(
  parameter int NIBBLES    = 3,
  parameter int IRQ_CYCLES = 12
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fetch_i,
  input  logic      pset_i,
  input  logic      jump_i,
  input  logic      call_i,
  input  logic      ret_i,
  input  logic      ei_i,
  input  logic      di_i,
  input  logic      irq_req_i,
  output logic      acc_fetch_o,
  output logic      acc_pset_o,
  output logic      acc_jump_o,
  output logic      acc_call_o,
  output logic      acc_ret_o,
  output logic      take_irq_o,
  output sq_state_e state_o,
  output logic [$clog2(IRQ_CYCLES)-1:0] cnt_o,
  output logic      seq_last_o,
  output logic      busy_o,
  output logic      ie_o,
  output logic      hold_o
);

  localparam int CNT_W = $clog2(IRQ_CYCLES);

  sq_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ie_q, ie_d;
  logic             hold_q, hold_d;
  logic             any_req;
  logic             busy;
  logic             seq_last;

  assign busy    = (state_q != SQ_IDLE);
  assign any_req = fetch_i | pset_i | jump_i | call_i | ret_i;

  // strobe acceptance with fixed priority: call, ret, jump, pset, fetch
  always_comb begin
    acc_call_o  = !busy && call_i;
    acc_ret_o   = !busy && ret_i && !call_i;
    acc_jump_o  = !busy && jump_i && !call_i && !ret_i;
    acc_pset_o  = !busy && pset_i && !jump_i && !call_i && !ret_i;
    acc_fetch_o = !busy && fetch_i && !pset_i && !jump_i && !call_i && !ret_i;
    take_irq_o  = !busy && !any_req && irq_req_i && ie_q && !hold_q;
  end

  always_comb begin
    case (state_q)
      SQ_PUSH, SQ_POP: seq_last = (cnt_q == CNT_W'(NIBBLES - 1));
      SQ_IRQ:          seq_last = (cnt_q == CNT_W'(IRQ_CYCLES - 1));
      default:         seq_last = 1'b0;
    endcase
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ie_d    = ie_q;
    hold_d  = hold_q;
    if (busy) begin
      if (seq_last) begin
        state_d = SQ_IDLE;
        cnt_d   = '0;
      end else begin
        cnt_d   = cnt_q + 1'b1;
      end
    end else if (acc_call_o) begin
      state_d = SQ_PUSH;
      cnt_d   = '0;
    end else if (acc_ret_o) begin
      state_d = SQ_POP;
      cnt_d   = '0;
    end else if (take_irq_o) begin
      state_d = SQ_IRQ;
      cnt_d   = '0;
    end
    if (acc_pset_o) begin
      hold_d = 1'b1;
    end else if (acc_fetch_o || acc_jump_o || acc_call_o || acc_ret_o) begin
      hold_d = 1'b0;
    end
    if (take_irq_o || di_i) begin
      ie_d = 1'b0;
    end else if (ei_i) begin
      ie_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      ie_q    <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ie_q    <= ie_d;
      hold_q  <= hold_d;
    end
  end

  assign state_o    = state_q;
  assign cnt_o      = cnt_q;
  assign seq_last_o = seq_last;
  assign busy_o     = busy;
  assign ie_o       = ie_q;
  assign hold_o     = hold_q;

endmodule

// File: rtl/pcseq_stack_if.sv
module pcseq_stack_if
  import pcseq_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          NIB_W      = 4,
  parameter int          SP_W       = 8,
  parameter int          IRQ_CYCLES = 12,
  parameter logic [SP_W-1:0] SP_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sq_state_e         state_i,
  input  logic [$clog2(IRQ_CYCLES)-1:0] cnt_i,
  input  logic              acc_call_i,
  input  logic              take_irq_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [NIB_W-1:0]  rdata_i,
  output logic [SP_W-1:0]   addr_o,
  output logic [NIB_W-1:0]  wdata_o,
  output logic              we_o,
  output logic              re_o,
  output logic [ADDR_W-1:0] pop_addr_o,
  output logic [SP_W-1:0]   sp_o
);

  localparam int NIBBLES = ADDR_W / NIB_W;
  localparam int CNT_W   = $clog2(IRQ_CYCLES);

  logic [SP_W-1:0]   sp_q, sp_d;
  logic [ADDR_W-1:0] ret_q, ret_d;
  logic [ADDR_W-1:0] pop_q, pop_d;
  logic              push_act;
  logic              pop_act;
  logic [ADDR_W-1:0] pop_next;

  assign push_act = (state_i == SQ_PUSH) ||
                    ((state_i == SQ_IRQ) && (cnt_i < CNT_W'(NIBBLES)));
  assign pop_act  = (state_i == SQ_POP);

  // popped nibbles enter at the top and shift toward the low end
  assign pop_next = {rdata_i, pop_q[ADDR_W-1:NIB_W]};

  // most significant nibble is written first
  always_comb begin
    wdata_o = '0;
    if (push_act) begin
      for (int k = 0; k < NIBBLES; k++) begin
        if (int'(cnt_i) == k) begin
          wdata_o = ret_q[NIB_W*(NIBBLES-1-k) +: NIB_W];
        end
      end
    end
  end

  always_comb begin
    sp_d  = sp_q;
    ret_d = ret_q;
    pop_d = pop_q;
    if (acc_call_i) begin
      ret_d = pc_i + 1'b1;
    end else if (take_irq_i) begin
      ret_d = pc_i;
    end
    if (push_act) begin
      sp_d = sp_q - 1'b1;
    end else if (pop_act) begin
      sp_d  = sp_q + 1'b1;
      pop_d = pop_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= SP_RESET;
      ret_q <= '0;
      pop_q <= '0;
    end else begin
      sp_q  <= sp_d;
      ret_q <= ret_d;
      pop_q <= pop_d;
    end
  end

  assign addr_o     = push_act ? (sp_q - 1'b1) : sp_q;
  assign we_o       = push_act;
  assign re_o       = pop_act;
  assign pop_addr_o = pop_next;
  assign sp_o       = sp_q;

endmodule

// File: rtl/pcseq_pc_reg.sv
module pcseq_pc_reg
  import pcseq_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int STEP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_fetch_i,
  input  logic                     acc_pset_i,
  input  logic                     acc_jump_i,
  input  logic                     acc_call_i,
  input  logic                     acc_ret_i,
  input  logic                     take_irq_i,
  input  logic                     seq_last_i,
  input  sq_state_e                state_i,
  input  logic [STEP_W-1:0]        imm_i,
  input  logic [PAGE_W+STEP_W-1:0] vec_i,
  input  logic [PAGE_W+STEP_W-1:0] pop_addr_i,
  output logic [PAGE_W+STEP_W-1:0] pc_o
);

  localparam int ADDR_W = PAGE_W + STEP_W;

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d;
  logic [PAGE_W-1:0] pend_q, pend_d;
  logic              pend_v_q, pend_v_d;
  logic [PAGE_W-1:0] cur_page;
  logic [STEP_W-1:0] cur_step;
  logic [PAGE_W-1:0] sel_page;

  assign cur_page = pc_q[ADDR_W-1:STEP_W];
  assign cur_step = pc_q[STEP_W-1:0];
  assign sel_page = pend_v_q ? pend_q : cur_page;

  always_comb begin
    pc_d     = pc_q;
    tgt_d    = tgt_q;
    pend_d   = pend_q;
    pend_v_d = pend_v_q;
    if (acc_fetch_i || acc_pset_i) begin
      pc_d = {cur_page, cur_step + 1'b1};
    end else if (acc_jump_i) begin
      pc_d = {sel_page, imm_i};
    end else if (seq_last_i) begin
      pc_d = (state_i == SQ_POP) ? pop_addr_i : tgt_q;
    end
    if (acc_call_i) begin
      tgt_d = {sel_page, imm_i};
    end else if (take_irq_i) begin
      tgt_d = vec_i;
    end
    if (acc_pset_i) begin
      pend_d   = imm_i[PAGE_W-1:0];
      pend_v_d = 1'b1;
    end else if (acc_fetch_i || acc_jump_i || acc_call_i || acc_ret_i) begin
      pend_v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      tgt_q    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else begin
      pc_q     <= pc_d;
      tgt_q    <= tgt_d;
      pend_q   <= pend_d;
      pend_v_q <= pend_v_d;
    end
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int PAGE_W     = 4,
  parameter int STEP_W     = 8,
  parameter int NIB_W      = 4,
  parameter int SP_W       = 8,
  parameter int IRQ_CYCLES = 12,
  parameter logic [SP_W-1:0] SP_RESET = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fetch_i,
  input  logic                     pset_i,
  input  logic                     jump_i,
  input  logic                     call_i,
  input  logic                     ret_i,
  input  logic                     ei_i,
  input  logic                     di_i,
  input  logic [STEP_W-1:0]        imm_i,
  input  logic                     irq_req_i,
  input  logic [PAGE_W+STEP_W-1:0] irq_vec_i,
  input  logic [NIB_W-1:0]         stk_rdata_i,
  output logic [PAGE_W+STEP_W-1:0] pc_o,
  output logic [SP_W-1:0]          stk_addr_o,
  output logic [NIB_W-1:0]         stk_wdata_o,
  output logic                     stk_we_o,
  output logic                     stk_re_o,
  output logic                     busy_o,
  output logic                     ie_o
);

  localparam int ADDR_W  = PAGE_W + STEP_W;
  localparam int NIBBLES = ADDR_W / NIB_W;
  localparam int CNT_W   = $clog2(IRQ_CYCLES);

  // reset assertion is asynchronous, release follows two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_int = rst_sync_q[1];

  logic              acc_fetch, acc_pset, acc_jump, acc_call, acc_ret;
  logic              take_irq;
  sq_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic              seq_last;
  logic              hold;
  logic [ADDR_W-1:0] pop_addr;
  logic [SP_W-1:0]   sp;

  pcseq_ctrl #(
    .NIBBLES    (NIBBLES),
    .IRQ_CYCLES (IRQ_CYCLES)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .fetch_i     (fetch_i),
    .pset_i      (pset_i),
    .jump_i      (jump_i),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .ei_i        (ei_i),
    .di_i        (di_i),
    .irq_req_i   (irq_req_i),
    .acc_fetch_o (acc_fetch),
    .acc_pset_o  (acc_pset),
    .acc_jump_o  (acc_jump),
    .acc_call_o  (acc_call),
    .acc_ret_o   (acc_ret),
    .take_irq_o  (take_irq),
    .state_o     (state),
    .cnt_o       (cnt),
    .seq_last_o  (seq_last),
    .busy_o      (busy_o),
    .ie_o        (ie_o),
    .hold_o      (hold)
  );

  pcseq_stack_if #(
    .ADDR_W     (ADDR_W),
    .NIB_W      (NIB_W),
    .SP_W       (SP_W),
    .IRQ_CYCLES (IRQ_CYCLES),
    .SP_RESET   (SP_RESET)
  ) u_stack (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .state_i    (state),
    .cnt_i      (cnt),
    .acc_call_i (acc_call),
    .take_irq_i (take_irq),
    .pc_i       (pc_o),
    .rdata_i    (stk_rdata_i),
    .addr_o     (stk_addr_o),
    .wdata_o    (stk_wdata_o),
    .we_o       (stk_we_o),
    .re_o       (stk_re_o),
    .pop_addr_o (pop_addr),
    .sp_o       (sp)
  );

  pcseq_pc_reg #(
    .PAGE_W (PAGE_W),
    .STEP_W (STEP_W)
  ) u_pc (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .acc_fetch_i (acc_fetch),
    .acc_pset_i  (acc_pset),
    .acc_jump_i  (acc_jump),
    .acc_call_i  (acc_call),
    .acc_ret_i   (acc_ret),
    .take_irq_i  (take_irq),
    .seq_last_i  (seq_last),
    .state_i     (state),
    .imm_i       (imm_i),
    .vec_i       (irq_vec_i),
    .pop_addr_i  (pop_addr),
    .pc_o        (pc_o)
  );

endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
  parameter int PAGE_W     = 4,
  parameter int STEP_W     = 8,
  parameter int SP_W       = 8,
  parameter int NIBBLES    = 3,
  parameter int IRQ_CYCLES = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [PAGE_W+STEP_W-1:0] pc,
  input logic                     busy,
  input logic                     we,
  input logic                     re,
  input logic                     ie,
  input logic                     hold,
  input logic                     acc_fetch,
  input logic                     take_irq,
  input logic [SP_W-1:0]          sp
);

  localparam int ADDR_W = PAGE_W + STEP_W;

  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else begin
      run_q <= busy ? run_q + 1'b1 : 8'd0;
    end
  end

  AST_FETCH_STEP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fetch |=> (pc[STEP_W-1:0] == $past(pc[STEP_W-1:0]) + 1'b1) &&
                  (pc[ADDR_W-1:STEP_W] == $past(pc[ADDR_W-1:STEP_W]))); // R2

  AST_PUSH_SP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (sp == $past(sp) - 1'b1)); // R5

  AST_POP_SP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    re |=> (sp == $past(sp) + 1'b1)); // R7

  AST_SEQ_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ((run_q == 8'(NIBBLES)) || (run_q == 8'(IRQ_CYCLES)))); // R8

  AST_ENTRY_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> (!ie && busy)); // R8

  AST_HOLD_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !take_irq); // R9

  AST_PC_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(pc)); // R10

endmodule

bind pc_sequencer pcseq_checker #(
  .PAGE_W     (PAGE_W),
  .STEP_W     (STEP_W),
  .SP_W       (SP_W),
  .NIBBLES    (NIBBLES),
  .IRQ_CYCLES (IRQ_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .pc        (pc_o),
  .busy      (busy_o),
  .we        (stk_we_o),
  .re        (stk_re_o),
  .ie        (ie_o),
  .hold      (hold),
  .acc_fetch (acc_fetch),
  .take_irq  (take_irq),
  .sp        (sp)
);

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_i, pset_i, jump_i, call_i, ret_i, ei_i, di_i;
  logic [7:0]  imm_i;
  logic        irq_req_i;
  logic [11:0] irq_vec_i;
  logic [3:0]  stk_rdata_i;
  logic [11:0] pc_o;
  logic [7:0]  stk_addr_o;
  logic [3:0]  stk_wdata_o;
  logic        stk_we_o, stk_re_o, busy_o, ie_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench-side model state
  logic [11:0] m_pc;
  logic [7:0]  m_sp;
  logic [3:0]  m_pend;
  bit          m_pv;
  logic [11:0] rstk [64];
  int          depth = 0;

  // external stack memory
  logic [3:0] smem [256];

  always #2.5 clk = ~clk;

  pc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .pset_i(pset_i),
    .jump_i(jump_i), .call_i(call_i), .ret_i(ret_i), .ei_i(ei_i),
    .di_i(di_i), .imm_i(imm_i), .irq_req_i(irq_req_i),
    .irq_vec_i(irq_vec_i), .stk_rdata_i(stk_rdata_i), .pc_o(pc_o),
    .stk_addr_o(stk_addr_o), .stk_wdata_o(stk_wdata_o),
    .stk_we_o(stk_we_o), .stk_re_o(stk_re_o), .busy_o(busy_o), .ie_o(ie_o)
  );

  always_ff @(posedge clk) begin
    if (stk_we_o) smem[stk_addr_o] <= stk_wdata_o;
  end
  assign stk_rdata_i = smem[stk_addr_o];

  function automatic logic [11:0] step_inc(input logic [11:0] a);
    return {a[11:8], a[7:0] + 8'd1};
  endfunction

  function automatic logic [3:0] sel_page();
    return m_pv ? m_pend : m_pc[11:8];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig, input logic [7:0] imm);
    @(negedge clk);
    sig   = 1'b1;
    imm_i = imm;
    @(negedge clk);
    sig   = 1'b0;
  endtask

  task automatic op_fetch();
    pulse(fetch_i, 8'h00);
    m_pc = step_inc(m_pc);
    m_pv = 0;
    check("R2 fetch", 32'(pc_o), 32'(m_pc));
  endtask

  task automatic op_pset(input logic [3:0] p);
    pulse(pset_i, {4'h0, p});
    m_pc   = step_inc(m_pc);
    m_pend = p;
    m_pv   = 1;
    check("R4 pset step", 32'(pc_o), 32'(m_pc));
  endtask

  task automatic op_jump(input logic [7:0] t);
    pulse(jump_i, t);
    m_pc = {sel_page(), t};
    m_pv = 0;
    check("R3 jump", 32'(pc_o), 32'(m_pc));
  endtask

  task automatic op_call(input logic [7:0] t, input bit inject);
    logic [11:0] ra;
    int n;
    ra = m_pc + 12'd1;
    pulse(call_i, t);
    n = 0;
    while (busy_o === 1'b1 && n < 40) begin
      // R10: a strobe during the sequence must be ignored
      jump_i = (inject && n == 0);
      imm_i  = 8'h5A;
      n++;
      @(negedge clk);
    end
    jump_i = 1'b0;
    check("R5 call busy length", n, 3);
    check("R5 push page", 32'(smem[m_sp - 8'd1]), 32'(ra[11:8]));
    check("R5 push step hi", 32'(smem[m_sp - 8'd2]), 32'(ra[7:4]));
    check("R5 push step lo", 32'(smem[m_sp - 8'd3]), 32'(ra[3:0]));
    m_sp = m_sp - 8'd3;
    rstk[depth] = ra;
    depth++;
    m_pc = {sel_page(), t};
    m_pv = 0;
    check(inject ? "R10 call target after ignored jump" : "R5 call target",
          32'(pc_o), 32'(m_pc));
  endtask

  task automatic op_ret();
    int n;
    pulse(ret_i, 8'h00);
    n = 0;
    while (busy_o === 1'b1 && n < 40) begin
      n++;
      @(negedge clk);
    end
    check("R7 ret busy length", n, 3);
    depth--;
    m_pc = rstk[depth];
    m_sp = m_sp + 8'd3;
    m_pv = 0;
    check("R7 ret address", 32'(pc_o), 32'(m_pc));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    {fetch_i, pset_i, jump_i, call_i, ret_i, ei_i, di_i, irq_req_i} = '0;
    imm_i = '0;
    irq_vec_i = '0;
    for (int i = 0; i < 256; i++) smem[i] = 4'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_pc = '0; m_sp = 8'h00; m_pv = 0;

    // R1: reset state
    check("R1 pc", 32'(pc_o), 0);
    check("R1 busy", 32'(busy_o), 0);
    check("R1 ie", 32'(ie_o), 0);
    check("R1 stack req", 32'({stk_we_o, stk_re_o}), 0);
    check("R1 sp", 32'(stk_addr_o), 0);

    // R2: step wraps inside the page
    op_jump(8'hFE);
    op_fetch();
    op_fetch();
    check("R2 wrap keeps page", 32'(pc_o), 32'h000);

    // R4: preset consumed by jump; a later jump uses the current page
    op_pset(4'h7);
    op_jump(8'h12);
    check("R4 armed page used", 32'(pc_o[11:8]), 7);
    op_pset(4'h2);
    op_fetch();
    op_jump(8'h34);
    check("R4 preset discarded by fetch", 32'(pc_o[11:8]), 7);

    // R6: carry into page, and full wrap
    op_pset(4'h3);
    op_jump(8'hFF);
    op_call(8'h10, 1'b0);
    check("R6 carry page saved", 32'(smem[m_sp + 8'd2]), 4);
    op_ret();
    check("R6 return after carry", 32'(pc_o), 32'h400);
    op_pset(4'hF);
    op_jump(8'hFF);
    op_call(8'h20, 1'b0);
    op_ret();
    check("R6 full wrap", 32'(pc_o), 32'h000);

    // R10: jump during call sequence ignored
    op_call(8'h40, 1'b1);
    op_ret();

    // R11: enable control
    pulse(ei_i, 8'h00);
    check("R11 ei sets", 32'(ie_o), 1);
    pulse(di_i, 8'h00);
    check("R11 di clears", 32'(ie_o), 0);

    // R8: request ignored while disabled
    irq_vec_i = 12'hA5C;
    @(negedge clk);
    irq_req_i = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 disabled no entry", 32'(busy_o), 0);
    check("R8 disabled pc", 32'(pc_o), 32'(m_pc));
    irq_req_i = 1'b0;

    // R9: preset holds off the interrupt until next instruction
    pulse(ei_i, 8'h00);
    op_pset(4'h9);
    irq_req_i = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 held after pset", 32'(busy_o), 0);
    pulse(fetch_i, 8'h00);
    m_pc = step_inc(m_pc);
    m_pv = 0;
    check("R9 fetch done, no entry yet", 32'(busy_o), 0);
    @(negedge clk);
    check("R8 entry after release", 32'(busy_o), 1);
    irq_req_i = 1'b0;
    n = 1;
    @(negedge clk);
    while (busy_o === 1'b1 && n < 40) begin
      n++;
      @(negedge clk);
    end
    check("R8 entry length", n, 12);
    check("R8 vector loaded", 32'(pc_o), 32'hA5C);
    check("R8 ie cleared", 32'(ie_o), 0);
    check("R8 saved page", 32'(smem[m_sp - 8'd1]), 32'(m_pc[11:8]));
    check("R8 saved lo", 32'(smem[m_sp - 8'd3]), 32'(m_pc[3:0]));
    m_sp = m_sp - 8'd3;
    rstk[depth] = m_pc;
    depth++;
    m_pc = 12'hA5C;
    op_ret();

    // random mix
    for (int i = 0; i < 400; i++) begin
      int k;
      k = int'($urandom_range(0, 4));
      case (k)
        0: op_fetch();
        1: op_pset(4'($urandom_range(0, 15)));
        2: op_jump(8'($urandom_range(0, 255)));
        3: if (depth < 40) op_call(8'($urandom_range(0, 255)), 1'b0);
           else op_ret();
        default: if (depth > 0) op_ret(); else op_fetch();
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule